// File: doc/BRIEF.md
# Paged Memory Card Configuration Registers

This block is the control logic on the card side of a linear flash memory card that sits on a PCMCIA-style host bus. It holds two small registers in attribute space. The option register carries a soft-reset bit and a two-bit page number. The status register carries a power-down bit. Host writes land on the rising edge of the write strobe. The strobe and the bus fields are carried into the card clock domain through a synchronizer chain before a register changes.

For array traffic, the block joins the page number with the two top address bits to pick one pair of 8-bit flash devices, which together form a 16-bit word. Each page covers 64MB. The fourth page code maps to no memory. The block fans a single active-low reset/power-down level out to every device. That line is asserted by the soft-reset bit, the power-down bit, or the card reset pin. The block also folds the ready/busy lines of all devices into one card-level ready output.

Top module: `card_cfg_top`

## Requirements
- R1: The option register is at attribute byte address 4000h and the status register at 4002h. Both respond only when attr_ni is low and ce_ni[0] is low. The same strobe with attr_ni high leaves both registers unchanged.
- R2: Writing a 1 to option bit 7 enters soft reset. While in soft reset, every dev_rp_no bit is 0 and dev_en_o is 0. Entering soft reset clears the page to 00 and the power-down bit to 0.
- R3: During soft reset, a write of 0 to option bit 7 leaves soft reset with page 00, whatever the page bits of that write hold. Status writes during soft reset are ignored, and option writes with bit 7 at 1 change nothing.
- R4: Outside soft reset, an option write sets the page from data bits 1:0. An array access enables pair index page*4 + addr_i[25:24]; bit n of dev_en_o is pair n.
- R5: With page code 11, no pair is enabled for any array read or write.
- R6: Status bit 2 at 1 drives every dev_rp_no bit to 0 and blocks array enables. Writing it to 0 restores standby (all 1). It resets to 0.
- R7: While card_rst_i is high, every dev_rp_no bit is 0 at once. It also clears all register state, and the state stays cleared until the pin has been low through the synchronizer.
- R8: card_rdy_o is 1 only when every dev_rdy_i bit is 1.
- R9: A register read (attr_ni, ce_ni[0] and oe_ni low) returns soft reset on bit 7 and the page on bits 1:0 for the option register, and power-down on bit 2 for the status register. All other bits, and rdata_o outside a register read, are 0.
- R10: Writes to any other attribute address leave both registers unchanged.
- R11: A register write uses the bus fields sampled at the last clock edge before we_ni rises. It takes effect at the third rising clock edge after the rise.
- R12: An array access needs attr_ni high, at least one ce_ni bit low, and oe_ni or we_ni low. At most one dev_en_o bit is ever set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Card clock |
| rst_ni | input | 1 | Power-on reset, active low, asynchronous |
| card_rst_i | input | 1 | Card reset pin, active high |
| attr_ni | input | 1 | Attribute space select, active low |
| ce_ni | input | 2 | Card enables, bit 0 even byte, bit 1 odd byte, active low |
| oe_ni | input | 1 | Output enable, active low |
| we_ni | input | 1 | Write strobe, active low |
| addr_i | input | 26 | Byte address |
| wdata_i | input | 8 | Write data, even byte lane |
| rdata_o | output | 8 | Register read data, even byte lane |
| dev_en_o | output | 12 | One enable per device pair |
| dev_rp_no | output | 24 | Reset/power-down to each device, active low |
| dev_rdy_i | input | 24 | Ready from each device, high when ready |
| card_rdy_o | output | 1 | Merged card ready |

## Verification
The hardest state to reach is the pair of writes around soft reset. A status write and a page-carrying option write land while the card is in soft reset. Then the exit write carries nonzero page bits that must be dropped. The stimulus sets up a nonzero page and power-down first, so that a clearing failure shows. It then chains these writes and reads both registers back after the exit. Write latency is probed by holding a read of the option register open while the strobe rises, then sampling rdata_o after each of the next three edges.

// File: rtl/card_cfg_pkg.sv
package card_cfg_pkg;
  localparam int PAGE_W       = 2;
  localparam int REG_W        = 8;
  localparam int OPT_SRST_BIT = 7;
  localparam int STAT_PD_BIT  = 2;
  localparam logic [PAGE_W-1:0] PAGE_NONE = 2'b11;

  typedef enum logic [1:0] {
    REG_NONE,
    REG_OPT,
    REG_STAT
  } reg_sel_e;

  typedef struct packed {
    logic              srst;
    logic              pd;
    logic [PAGE_W-1:0] page;
  } cfg_state_t;
endpackage

// File: rtl/card_cfg_sync.sv
module card_cfg_sync #(
  parameter int ADDR_W = 26,
  parameter int DATA_W = 8,
  parameter int STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_ni,
  input  logic              card_rst_i,
  input  logic              attr_ni,
  input  logic              ce0_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              wr_stb_o,
  output logic              wr_attr_no,
  output logic              wr_ce0_no,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [DATA_W-1:0] wr_data_o,
  output logic              hw_rst_o
);
  localparam int BUS_W = 2 + ADDR_W + DATA_W;

  logic [STAGES:0]   we_q;
  logic [STAGES-1:0] rst_q;
  logic [BUS_W-1:0]  bus_q [STAGES+1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      we_q  <= '1;
      rst_q <= '0;
      for (int i = 0; i <= STAGES; i++) bus_q[i] <= '0;
    end else begin
      we_q[0]  <= we_ni;
      rst_q[0] <= card_rst_i;
      bus_q[0] <= {attr_ni, ce0_ni, addr_i, wdata_i};
      for (int i = 1; i <= STAGES; i++) begin
        we_q[i]  <= we_q[i-1];
        bus_q[i] <= bus_q[i-1];
      end
      for (int i = 1; i < STAGES; i++) rst_q[i] <= rst_q[i-1];
    end
  end

  // rising edge of the synchronized strobe; fields travel one stage behind
  assign wr_stb_o = we_q[STAGES-1] & ~we_q[STAGES];
  assign {wr_attr_no, wr_ce0_no, wr_addr_o, wr_data_o} = bus_q[STAGES];
  assign hw_rst_o = rst_q[STAGES-1];
endmodule

// File: rtl/card_cfg_regfile.sv
module card_cfg_regfile
  import card_cfg_pkg::*;
#(
  parameter int               ADDR_W    = 26,
  parameter logic [ADDR_W-1:0] OPT_ADDR  = 26'h4000,
  parameter logic [ADDR_W-1:0] STAT_ADDR = 26'h4002
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_stb_i,
  input  logic              wr_attr_ni,
  input  logic              wr_ce0_ni,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [REG_W-1:0]  wr_data_i,
  input  logic              hw_rst_i,
  input  logic              rd_attr_ni,
  input  logic              rd_ce0_ni,
  input  logic              rd_oe_ni,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output cfg_state_t        state_o,
  output logic [REG_W-1:0]  rd_data_o
);
  cfg_state_t state_q;
  reg_sel_e   wr_sel, rd_sel;

  function automatic reg_sel_e decode(logic attr_n, logic ce0_n, logic [ADDR_W-1:0] a);
    if (attr_n || ce0_n)  return REG_NONE;
    if (a == OPT_ADDR)    return REG_OPT;
    if (a == STAT_ADDR)   return REG_STAT;
    return REG_NONE;
  endfunction

  assign wr_sel = decode(wr_attr_ni, wr_ce0_ni, wr_addr_i);
  assign rd_sel = decode(rd_attr_ni, rd_ce0_ni, rd_addr_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= '0;
    end else if (hw_rst_i) begin
      state_q <= '0;
    end else if (wr_stb_i) begin
      unique case (wr_sel)
        REG_OPT: begin
          if (state_q.srst) begin
            if (!wr_data_i[OPT_SRST_BIT]) state_q.srst <= 1'b0;
          end else if (wr_data_i[OPT_SRST_BIT]) begin
            state_q <= '{srst: 1'b1, pd: 1'b0, page: '0};
          end else begin
            state_q.page <= wr_data_i[PAGE_W-1:0];
          end
        end
        REG_STAT: if (!state_q.srst) state_q.pd <= wr_data_i[STAT_PD_BIT];
        default: ;
      endcase
    end
  end

  always_comb begin
    rd_data_o = '0;
    if (!rd_oe_ni) begin
      unique case (rd_sel)
        REG_OPT: begin
          rd_data_o[OPT_SRST_BIT]  = state_q.srst;
          rd_data_o[PAGE_W-1:0]    = state_q.page;
        end
        REG_STAT: rd_data_o[STAT_PD_BIT] = state_q.pd;
        default: ;
      endcase
    end
  end

  assign state_o = state_q;

  // R7
  hw_rst_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hw_rst_i |=> (state_q == '0));
  // R3
  srst_clean_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q.srst |-> (state_q.page == '0 && !state_q.pd));
  // R11
  no_stray_update_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_stb_i && !hw_rst_i) |=> $stable(state_q));
  // R10
  undecoded_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_stb_i && !hw_rst_i && wr_sel == REG_NONE) |=> $stable(state_q));
endmodule

// File: rtl/card_cfg_devsel.sv
module card_cfg_devsel
  import card_cfg_pkg::*;
#(
  parameter int ADDR_W      = 26,
  parameter int PAIR_ADDR_W = 24,
  parameter int NUM_PAIRS   = 12,
  localparam int SEL_W      = ADDR_W - PAIR_ADDR_W,
  localparam int NUM_DEV    = 2 * NUM_PAIRS
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  cfg_state_t           state_i,
  input  logic                 hw_rst_i,
  input  logic                 card_rst_i,
  input  logic                 attr_ni,
  input  logic [1:0]           ce_ni,
  input  logic                 oe_ni,
  input  logic                 we_ni,
  input  logic [SEL_W-1:0]     addr_hi_i,
  input  logic [NUM_DEV-1:0]   dev_rdy_i,
  output logic [NUM_PAIRS-1:0] dev_en_o,
  output logic [NUM_DEV-1:0]   dev_rp_no,
  output logic                 card_rdy_o
);
  localparam int IDX_W = PAGE_W + SEL_W;

  logic             pd_all;
  logic             access;
  logic [IDX_W-1:0] pair_idx;

  assign pd_all   = state_i.srst | state_i.pd | hw_rst_i | card_rst_i;
  assign access   = attr_ni & ~(&ce_ni) & (~oe_ni | ~we_ni) & ~pd_all
                  & (state_i.page != PAGE_NONE);
  assign pair_idx = {state_i.page, addr_hi_i};

  for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair
    assign dev_en_o[p] = access && (pair_idx == IDX_W'(p));
  end

  for (genvar d = 0; d < NUM_DEV; d++) begin : g_rp
    assign dev_rp_no[d] = ~pd_all;
  end

  assign card_rdy_o = &dev_rdy_i;

  // R12
  pair_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(dev_en_o));
  // R5
  no_page3_access_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i.page == PAGE_NONE) |-> (dev_en_o == '0));
  // R2
  srst_pd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_i.srst |-> (dev_rp_no == '0));
  // R6
  pd_no_access_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!dev_rp_no[0]) |-> (dev_en_o == '0));
  // R8
  busy_merge_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    card_rdy_o |-> ($countones(dev_rdy_i) == NUM_DEV));
endmodule

// File: rtl/card_cfg_top.sv
module card_cfg_top
  import card_cfg_pkg::*;
#(
  parameter int                ADDR_W      = 26,
  parameter int                PAIR_ADDR_W = 24,
  parameter int                NUM_PAIRS   = 12,
  parameter int                SYNC_STAGES = 2,
  parameter logic [ADDR_W-1:0] OPT_ADDR    = 26'h4000,
  parameter logic [ADDR_W-1:0] STAT_ADDR   = 26'h4002,
  localparam int               NUM_DEV     = 2 * NUM_PAIRS
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 card_rst_i,
  input  logic                 attr_ni,
  input  logic [1:0]           ce_ni,
  input  logic                 oe_ni,
  input  logic                 we_ni,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic [REG_W-1:0]     wdata_i,
  output logic [REG_W-1:0]     rdata_o,
  output logic [NUM_PAIRS-1:0] dev_en_o,
  output logic [NUM_DEV-1:0]   dev_rp_no,
  input  logic [NUM_DEV-1:0]   dev_rdy_i,
  output logic                 card_rdy_o
);
  logic              wr_stb, wr_attr_n, wr_ce0_n, hw_rst;
  logic [ADDR_W-1:0] wr_addr;
  logic [REG_W-1:0]  wr_data;
  cfg_state_t        state;

  card_cfg_sync #(
    .ADDR_W (ADDR_W),
    .DATA_W (REG_W),
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .we_ni      (we_ni),
    .card_rst_i (card_rst_i),
    .attr_ni    (attr_ni),
    .ce0_ni     (ce_ni[0]),
    .addr_i     (addr_i),
    .wdata_i    (wdata_i),
    .wr_stb_o   (wr_stb),
    .wr_attr_no (wr_attr_n),
    .wr_ce0_no  (wr_ce0_n),
    .wr_addr_o  (wr_addr),
    .wr_data_o  (wr_data),
    .hw_rst_o   (hw_rst)
  );

  card_cfg_regfile #(
    .ADDR_W    (ADDR_W),
    .OPT_ADDR  (OPT_ADDR),
    .STAT_ADDR (STAT_ADDR)
  ) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_stb_i   (wr_stb),
    .wr_attr_ni (wr_attr_n),
    .wr_ce0_ni  (wr_ce0_n),
    .wr_addr_i  (wr_addr),
    .wr_data_i  (wr_data),
    .hw_rst_i   (hw_rst),
    .rd_attr_ni (attr_ni),
    .rd_ce0_ni  (ce_ni[0]),
    .rd_oe_ni   (oe_ni),
    .rd_addr_i  (addr_i),
    .state_o    (state),
    .rd_data_o  (rdata_o)
  );

  card_cfg_devsel #(
    .ADDR_W      (ADDR_W),
    .PAIR_ADDR_W (PAIR_ADDR_W),
    .NUM_PAIRS   (NUM_PAIRS)
  ) u_devsel (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .state_i    (state),
    .hw_rst_i   (hw_rst),
    .card_rst_i (card_rst_i),
    .attr_ni    (attr_ni),
    .ce_ni      (ce_ni),
    .oe_ni      (oe_ni),
    .we_ni      (we_ni),
    .addr_hi_i  (addr_i[ADDR_W-1:PAIR_ADDR_W]),
    .dev_rdy_i  (dev_rdy_i),
    .dev_en_o   (dev_en_o),
    .dev_rp_no  (dev_rp_no),
    .card_rdy_o (card_rdy_o)
  );
endmodule

// File: tb/card_cfg_top_tb_top.sv
module card_cfg_top_tb_top;
  localparam int AW = 26;
  localparam int NP = 12;
  localparam int ND = 24;
  localparam logic [AW-1:0] OPT  = 26'h4000;
  localparam logic [AW-1:0] STAT = 26'h4002;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          card_rst_i = 1'b0;
  logic          attr_ni = 1'b1;
  logic [1:0]    ce_ni = 2'b11;
  logic          oe_ni = 1'b1;
  logic          we_ni = 1'b1;
  logic [AW-1:0] addr_i = '0;
  logic [7:0]    wdata_i = '0;
  logic [7:0]    rdata_o;
  logic [NP-1:0] dev_en_o;
  logic [ND-1:0] dev_rp_no;
  logic [ND-1:0] dev_rdy_i = '1;
  logic          card_rdy_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #4 clk = ~clk;

  card_cfg_top dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .card_rst_i(card_rst_i), .attr_ni(attr_ni),
    .ce_ni(ce_ni), .oe_ni(oe_ni), .we_ni(we_ni), .addr_i(addr_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .dev_en_o(dev_en_o),
    .dev_rp_no(dev_rp_no), .dev_rdy_i(dev_rdy_i), .card_rdy_o(card_rdy_o)
  );

  // reference model: register state plus a short history of sampled bus values
  bit m_srst, m_pd;
  bit [1:0] m_page;
  bit h_we [3], h_rst [3], h_attr [3], h_ce0 [3];
  bit [AW-1:0] h_addr [3];
  bit [7:0] h_dat [3];

  task automatic model_write(bit attr_n, bit ce0_n, bit [AW-1:0] a, bit [7:0] d);
    if (attr_n || ce0_n) return;
    if (a == OPT) begin
      if (m_srst) begin
        if (!d[7]) m_srst = 0;
      end else if (d[7]) begin
        m_srst = 1; m_page = 0; m_pd = 0;
      end else m_page = d[1:0];
    end else if (a == STAT) begin
      if (!m_srst) m_pd = d[2];
    end
  endtask

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      m_srst = 0; m_pd = 0; m_page = 0;
      for (int i = 0; i < 3; i++) begin
        h_we[i] = 1; h_rst[i] = 0; h_attr[i] = 0; h_ce0[i] = 0; h_addr[i] = 0; h_dat[i] = 0;
      end
    end else begin
      if (h_rst[1]) begin
        m_srst = 0; m_pd = 0; m_page = 0;
      end else if (h_we[1] && !h_we[2]) model_write(h_attr[2], h_ce0[2], h_addr[2], h_dat[2]);
      for (int i = 2; i > 0; i--) begin
        h_we[i] = h_we[i-1]; h_rst[i] = h_rst[i-1]; h_attr[i] = h_attr[i-1];
        h_ce0[i] = h_ce0[i-1]; h_addr[i] = h_addr[i-1]; h_dat[i] = h_dat[i-1];
      end
      h_we[0] = we_ni; h_rst[0] = card_rst_i; h_attr[0] = attr_ni;
      h_ce0[0] = ce_ni[0]; h_addr[0] = addr_i; h_dat[0] = wdata_i;
    end
  end

  function automatic bit m_pdall();
    return m_srst || m_pd || card_rst_i || h_rst[1];
  endfunction

  function automatic bit [NP-1:0] exp_en();
    int idx;
    bit acc;
    acc = attr_ni && (ce_ni != 2'b11) && (!oe_ni || !we_ni) && !m_pdall() && (m_page != 2'b11);
    idx = m_page * 4 + int'(addr_i[25:24]);
    if (!acc || idx >= NP) return '0;
    return NP'(1) << idx;
  endfunction

  function automatic bit [7:0] exp_rd();
    if (attr_ni || ce_ni[0] || oe_ni) return 8'h00;
    if (addr_i == OPT)  return {m_srst, 5'b0, m_page};
    if (addr_i == STAT) return {5'b0, m_pd, 2'b0};
    return 8'h00;
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_ni && !done) begin
      check("R1 R9 rdata", 32'(rdata_o), 32'(exp_rd()));
      check("R4 R5 R12 dev_en", 32'(dev_en_o), 32'(exp_en()));
      check("R2 R6 R7 dev_rp", 32'(dev_rp_no), m_pdall() ? 32'h0 : 32'(ND'('1)));
      check("R8 rdy", 32'(card_rdy_o), 32'(&dev_rdy_i));
    end
  end

  task automatic step(int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic idle();
    attr_ni = 1; ce_ni = 2'b11; oe_ni = 1; we_ni = 1;
  endtask

  task automatic wr(bit attr_n, bit [AW-1:0] a, bit [7:0] d);
    step(1);
    attr_ni = attr_n; ce_ni = 2'b10; addr_i = a; wdata_i = d; we_ni = 0;
    step(3);
    we_ni = 1;
    step(4);
    idle();
    step(1);
  endtask

  task automatic rd(bit [AW-1:0] a, output logic [7:0] v);
    step(1);
    attr_ni = 0; ce_ni = 2'b10; addr_i = a; oe_ni = 0;
    @(negedge clk);
    v = rdata_o;
    step(1);
    idle();
  endtask

  task automatic arr(bit [1:0] hi, output logic [NP-1:0] v);
    step(1);
    attr_ni = 1; ce_ni = 2'b00; addr_i = {hi, 24'h00_1234}; oe_ni = 0;
    @(negedge clk);
    v = dev_en_o;
    step(1);
    idle();
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin : main
    logic [7:0] v;
    logic [NP-1:0] e;
    #10;
    @(negedge clk);
    check("R6 reset rp", 32'(dev_rp_no), 32'(ND'('1)));
    check("R12 reset en", 32'(dev_en_o), 0);
    check("R9 reset rdata", 32'(rdata_o), 0);
    step(1);
    rst_ni = 1;
    step(2);
    rd(OPT, v);  check("R9 opt reset value", 32'(v), 0);
    rd(STAT, v); check("R6 stat reset value", 32'(v), 0);

    // page select
    wr(0, OPT, 8'h01);
    rd(OPT, v); check("R1 R4 page1 readback", 32'(v), 32'h01);
    arr(2'd2, e); check("R4 page1 hi2", 32'(e), 32'(1 << 6));
    wr(0, OPT, 8'h02);
    arr(2'd3, e); check("R4 page2 hi3", 32'(e), 32'(1 << 11));
    wr(0, OPT, 8'h7C);
    rd(OPT, v); check("R9 unsupported opt bits", 32'(v), 32'h00);
    arr(2'd0, e); check("R4 page0 hi0", 32'(e), 32'h1);
    wr(0, OPT, 8'h03);
    rd(OPT, v); check("R9 page3 readback", 32'(v), 32'h03);
    arr(2'd1, e); check("R5 page3 no access", 32'(e), 0);

    // common-memory strobe and undecoded attribute writes
    wr(0, OPT, 8'h01);
    wr(1, OPT, 8'h02);
    rd(OPT, v); check("R1 attr high ignored", 32'(v), 32'h01);
    wr(0, 26'h4004, 8'h84);
    wr(0, 26'h0000, 8'h86);
    rd(OPT, v);  check("R10 undecoded opt", 32'(v), 32'h01);
    rd(STAT, v); check("R10 undecoded stat", 32'(v), 32'h00);

    // power-down
    wr(0, STAT, 8'hFF);
    rd(STAT, v); check("R6 R9 stat readback", 32'(v), 32'h04);
    @(negedge clk); check("R6 rp asserted", 32'(dev_rp_no), 0);
    arr(2'd0, e); check("R6 no access in pd", 32'(e), 0);
    wr(0, STAT, 8'h00);
    @(negedge clk); check("R6 rp released", 32'(dev_rp_no), 32'(ND'('1)));

    // soft reset sequence
    wr(0, OPT, 8'h02);
    wr(0, STAT, 8'h04);
    wr(0, OPT, 8'h80);
    rd(OPT, v);  check("R2 srst set, page cleared", 32'(v), 32'h80);
    rd(STAT, v); check("R2 pd cleared", 32'(v), 32'h00);
    @(negedge clk); check("R2 rp in srst", 32'(dev_rp_no), 0);
    arr(2'd1, e); check("R2 no access in srst", 32'(e), 0);
    wr(0, STAT, 8'h04);
    wr(0, OPT, 8'h81);
    rd(OPT, v); check("R3 writes ignored in srst", 32'(v), 32'h80);
    wr(0, OPT, 8'h02);
    rd(OPT, v);  check("R3 exit page zero", 32'(v), 32'h00);
    rd(STAT, v); check("R3 stat write dropped", 32'(v), 32'h00);
    arr(2'd1, e); check("R3 access after exit", 32'(e), 32'h2);

    // write latency
    step(1);
    attr_ni = 0; ce_ni = 2'b10; addr_i = OPT; wdata_i = 8'h01; we_ni = 0;
    step(3);
    we_ni = 1; oe_ni = 0;
    @(negedge clk); check("R11 before edge1", 32'(rdata_o), 0);
    @(negedge clk); check("R11 after edge1", 32'(rdata_o), 0);
    @(negedge clk); check("R11 after edge2", 32'(rdata_o), 0);
    @(negedge clk); check("R11 after edge3", 32'(rdata_o), 32'h01);
    step(1);
    idle();

    // card reset pin
    step(1);
    card_rst_i = 1;
    @(negedge clk); check("R7 rp immediate", 32'(dev_rp_no), 0);
    step(4);
    card_rst_i = 0;
    step(4);
    rd(OPT, v); check("R7 registers cleared", 32'(v), 0);
    @(negedge clk); check("R7 rp released", 32'(dev_rp_no), 32'(ND'('1)));

    // ready merge
    step(1); dev_rdy_i = ~(ND'(1));
    @(negedge clk); check("R8 dev0 busy", 32'(card_rdy_o), 0);
    step(1); dev_rdy_i = ~(ND'(1) << (ND - 1));
    @(negedge clk); check("R8 last dev busy", 32'(card_rdy_o), 0);
    step(1); dev_rdy_i = '1;
    @(negedge clk); check("R8 all ready", 32'(card_rdy_o), 1);

    // access qualification
    step(1); attr_ni = 1; ce_ni = 2'b11; oe_ni = 0; addr_i = '0;
    @(negedge clk); check("R12 no card enable", 32'(dev_en_o), 0);
    step(1); ce_ni = 2'b01;
    @(negedge clk); check("R12 odd-lane enable", 32'(dev_en_o), 1);
    step(1); attr_ni = 0;
    @(negedge clk); check("R12 attribute space", 32'(dev_en_o), 0);
    step(1); attr_ni = 1; oe_ni = 1;
    @(negedge clk); check("R12 no strobe", 32'(dev_en_o), 0);
    step(1); idle();
    step(4);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule